// File: doc/BRIEF.md
# Lockable SMRAM Control Register Pair

This block holds the two one-byte control registers that govern system-management RAM visibility in a host bridge: a primary control byte and an extended control byte. Configuration software writes them one byte at a time through a simple offset/data/write-enable port. Each register only accepts changes on the bits its write mask allows. Both control bytes are driven out as registered values to the address decoder that steers memory accesses.

Each register has a write mask, and these masks are state in their own right. They load their permissive values at reset. They switch to fully read-only values in the cycle that the lock bit is first set. The write that sets the lock still lands, except that the open bit is forced low even if that same write asks for it. From then on neither register can change, the lock bit included, until the next synchronous reset.

Top module: `smm_cfg_regs`

## Requirements
- R1: After reset the primary byte reads 0x02 and the extended byte reads 0x38; 0x38 means the three cache-disable bits [5:3] are set.
- R2: Before the lock, a write to the primary offset (default 0x44) changes only bits [6:3], through mask 0x78: open=6, close=5, lock=4, global enable=3. Bits 7 and [2:0] keep their value. The new value is visible at the output after the clock edge that takes the write.
- R3: Before the lock, a write to the extended offset (default 0x45) changes only bits 7 and [2:0], through mask 0x87: high-window enable=7, segment size=[2:1], segment enable=0. Bit 6 stays 0 and the cache bits [5:3] stay 1.
- R4: A write to any other offset leaves both bytes unchanged.
- R5: A write that sets the lock bit (bit 4) leaves the open bit (bit 6) at 0, even when the same write sets it. The other writable bits of that write take effect.
- R6: Once the lock bit is 1, writes to either offset change nothing, and the lock bit cannot be cleared.
- R7: Reset after a lock restores both defaults and the permissive masks, so later writes take effect again.
- R8: A read request returns the addressed byte on the read data port one cycle later. The value returned is the one held before any write in the same cycle. Other offsets read 0x00, and the read data holds its value when no read is requested.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_addr | input | AW (8) | Configuration byte offset |
| cfg_wdata | input | 8 | Write data byte |
| cfg_we | input | 1 | Write enable |
| cfg_re | input | 1 | Read request |
| cfg_rdata | output | 8 | Registered read data |
| smm_ctl | output | 8 | Primary control byte to the decoder |
| smm_ext | output | 8 | Extended control byte to the decoder |

## Verification
The assertions assume one byte is written per cycle, on a single offset. They also assume that reset is the only way back to the unlocked masks, so the lock-stickiness and frozen-register properties may only be disabled by reset. The stimulus keeps to this by driving one offset per cycle and by clearing the lock bit in most random primary writes. Locked and unlocked periods then both run long between the occasional reset pulses. Directed steps cover the cases the random mix rarely reaches: a write that sets open and lock together, and writes after a lock.

// File: rtl/smm_cfg_pkg.sv
package smm_cfg_pkg;
  localparam int unsigned DW = 8;
  typedef logic [DW-1:0] cfg_byte_t;

  // primary control byte
  localparam cfg_byte_t CTL_RST     = 8'h02;
  localparam cfg_byte_t CTL_WM_OPEN = 8'h78;
  localparam cfg_byte_t CTL_WM_LOCK = 8'h00;
  localparam int unsigned CTL_OPEN_BIT = 6;
  localparam int unsigned CTL_LOCK_BIT = 4;

  // extended control byte
  localparam cfg_byte_t EXT_RST     = 8'h38;
  localparam cfg_byte_t EXT_WM_OPEN = 8'h87;
  localparam cfg_byte_t EXT_WM_LOCK = 8'h00;
  localparam int unsigned EXT_CACHE_LO = 3;
  localparam int unsigned EXT_CACHE_HI = 5;

  localparam int unsigned NREG = 2;
  localparam int unsigned IDX_CTL = 0;
  localparam int unsigned IDX_EXT = 1;
endpackage

// File: rtl/smm_mask_reg.sv
module smm_mask_reg #(
  parameter int unsigned DW = 8,
  parameter logic [DW-1:0] RST_VAL = '0,
  parameter logic [DW-1:0] WM_OPEN = '1,
  parameter logic [DW-1:0] WM_LOCK = '0,
  parameter logic [DW-1:0] CLR_ON_LOCK = '0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_hit,
  input  logic [DW-1:0] wdata,
  input  logic          lock_evt,
  output logic [DW-1:0] merged,
  output logic [DW-1:0] q
);
  logic [DW-1:0] wm;
  logic [DW-1:0] clr;

  // bits outside the current mask keep their stored value
  assign merged = (q & ~wm) | (wdata & wm);
  assign clr    = lock_evt ? CLR_ON_LOCK : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      q  <= RST_VAL;
      wm <= WM_OPEN;
    end else begin
      if (wr_hit) q <= merged & ~clr;
      if (lock_evt) wm <= WM_LOCK;
    end
  end

  // R4
  hold_no_write_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_hit |=> $stable(q));
endmodule

// File: rtl/smm_rd_port.sv
module smm_rd_port #(
  parameter int unsigned AW = 8,
  parameter int unsigned DW = 8,
  parameter logic [AW-1:0] CTL_OFS = 'h44,
  parameter logic [AW-1:0] EXT_OFS = 'h45
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          re,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] ctl,
  input  logic [DW-1:0] ext,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] sel;

  always_comb begin
    if (addr == CTL_OFS)      sel = ctl;
    else if (addr == EXT_OFS) sel = ext;
    else                      sel = '0;
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (re) rdata <= sel;
  end

  // R8
  rd_ctl_chk: assert property (@(posedge clk) disable iff (rst)
    (re && addr == CTL_OFS) |=> rdata == $past(ctl));
  // R8
  rd_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !re |=> $stable(rdata));
endmodule

// File: rtl/smm_cfg_regs.sv
module smm_cfg_regs
  import smm_cfg_pkg::*;
#(
  parameter int unsigned AW = 8,
  parameter logic [AW-1:0] CTL_OFS = 'h44,
  parameter logic [AW-1:0] EXT_OFS = 'h45
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] cfg_addr,
  input  logic [DW-1:0] cfg_wdata,
  input  logic          cfg_we,
  input  logic          cfg_re,
  output logic [DW-1:0] cfg_rdata,
  output logic [DW-1:0] smm_ctl,
  output logic [DW-1:0] smm_ext
);
  localparam logic [NREG-1:0][AW-1:0] OFS_TAB  = {EXT_OFS, CTL_OFS};
  localparam logic [NREG-1:0][DW-1:0] RST_TAB  = {EXT_RST, CTL_RST};
  localparam logic [NREG-1:0][DW-1:0] WMO_TAB  = {EXT_WM_OPEN, CTL_WM_OPEN};
  localparam logic [NREG-1:0][DW-1:0] WML_TAB  = {EXT_WM_LOCK, CTL_WM_LOCK};
  localparam logic [DW-1:0]           CTL_CLR  = DW'(1) << CTL_OPEN_BIT;
  localparam logic [NREG-1:0][DW-1:0] CLR_TAB  = {{DW{1'b0}}, CTL_CLR};

  logic [NREG-1:0]         wr_hit;
  logic [NREG-1:0][DW-1:0] merged;
  logic [NREG-1:0][DW-1:0] q;
  logic                    lock_evt;

  // lock is raised by a primary write whose masked result has the lock bit set
  assign lock_evt = wr_hit[IDX_CTL] & merged[IDX_CTL][CTL_LOCK_BIT];

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    assign wr_hit[i] = cfg_we && (cfg_addr == OFS_TAB[i]);
    smm_mask_reg #(
      .DW(DW), .RST_VAL(RST_TAB[i]), .WM_OPEN(WMO_TAB[i]),
      .WM_LOCK(WML_TAB[i]), .CLR_ON_LOCK(CLR_TAB[i])
    ) u_reg (
      .clk(clk), .rst(rst), .wr_hit(wr_hit[i]), .wdata(cfg_wdata),
      .lock_evt(lock_evt), .merged(merged[i]), .q(q[i])
    );
  end

  assign smm_ctl = q[IDX_CTL];
  assign smm_ext = q[IDX_EXT];

  smm_rd_port #(.AW(AW), .DW(DW), .CTL_OFS(CTL_OFS), .EXT_OFS(EXT_OFS)) u_rd (
    .clk(clk), .rst(rst), .re(cfg_re), .addr(cfg_addr),
    .ctl(smm_ctl), .ext(smm_ext), .rdata(cfg_rdata)
  );

  // R6
  lock_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    smm_ctl[CTL_LOCK_BIT] |=> smm_ctl[CTL_LOCK_BIT]);
  // R6
  frozen_chk: assert property (@(posedge clk) disable iff (rst)
    smm_ctl[CTL_LOCK_BIT] |=> ($stable(smm_ctl) && $stable(smm_ext)));
  // R5
  open_cleared_chk: assert property (@(posedge clk) disable iff (rst)
    smm_ctl[CTL_LOCK_BIT] |-> !smm_ctl[CTL_OPEN_BIT]);
  // R3
  cache_hw_chk: assert property (@(posedge clk) disable iff (rst)
    smm_ext[EXT_CACHE_HI:EXT_CACHE_LO] == '1);
  // R2
  ctl_ro_chk: assert property (@(posedge clk) disable iff (rst)
    (smm_ctl & ~CTL_WM_OPEN) == (CTL_RST & ~CTL_WM_OPEN));
endmodule

// File: tb/sim_smm_cfg_regs.sv
`timescale 1ns/1ps
module sim_smm_cfg_regs;
  localparam logic [7:0] A_CTL = 8'h44;
  localparam logic [7:0] A_EXT = 8'h45;

  logic clk = 0;
  logic rst = 1;
  logic [7:0] cfg_addr = '0, cfg_wdata = '0;
  logic cfg_we = 0, cfg_re = 0;
  logic [7:0] cfg_rdata, smm_ctl, smm_ext;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [7:0] m_ctl, m_ext;

  always #5 clk = ~clk;

  smm_cfg_regs u0 (
    .clk(clk), .rst(rst), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .cfg_we(cfg_we), .cfg_re(cfg_re), .cfg_rdata(cfg_rdata),
    .smm_ctl(smm_ctl), .smm_ext(smm_ext)
  );

  function automatic logic [7:0] ctl_next(logic [7:0] old, logic [7:0] d);
    logic [7:0] n;
    if (old[4]) return old;                       // locked: mask empty
    n = (old & ~8'h78) | (d & 8'h78);
    if (n[4]) n[6] = 1'b0;                        // lock forces open low
    return n;
  endfunction

  function automatic logic [7:0] ext_next(logic [7:0] old, logic [7:0] d, logic lk);
    if (lk) return old;
    return (old & ~8'h87) | (d & 8'h87);
  endfunction

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic do_reset(input string tag);
    @(negedge clk);
    rst = 1;
    repeat (2) @(negedge clk);
    rst = 0;
    m_ctl = 8'h02;
    m_ext = 8'h38;
    chk(smm_ctl, m_ctl, tag);
    chk(smm_ext, m_ext, tag);
  endtask

  task automatic step(input logic we, input logic re, input logic [7:0] a,
                      input logic [7:0] d, input string tag);
    logic [7:0] pc, pe, er;
    @(negedge clk);
    cfg_we = we; cfg_re = re; cfg_addr = a; cfg_wdata = d;
    pc = m_ctl; pe = m_ext;
    er = (a == A_CTL) ? pc : (a == A_EXT) ? pe : 8'h00;
    if (we && a == A_CTL) m_ctl = ctl_next(pc, d);
    if (we && a == A_EXT) m_ext = ext_next(pe, d, pc[4]);
    @(negedge clk);
    cfg_we = 0; cfg_re = 0;
    chk(smm_ctl, m_ctl, tag);
    chk(smm_ext, m_ext, tag);
    if (re) chk(cfg_rdata, er, "R8");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    do_reset("R1");
    step(0, 1, A_CTL, 8'h00, "R1");
    step(0, 1, A_EXT, 8'h00, "R1");
    step(0, 1, 8'h10, 8'h00, "R8");
    step(1, 1, A_CTL, 8'hEF, "R2");              // expect 0x6A
    chk(smm_ctl, 8'h6A, "R2");
    step(1, 0, A_EXT, 8'h00, "R3");              // cache bits hold: 0x38
    chk(smm_ext, 8'h38, "R3");
    step(1, 1, A_EXT, 8'hFF, "R3");              // 0xBF
    chk(smm_ext, 8'hBF, "R3");
    step(1, 0, 8'h46, 8'hFF, "R4");
    step(1, 0, 8'h43, 8'h00, "R4");
    step(1, 0, A_CTL, 8'h50, "R5");              // open+lock in one write: 0x12
    chk(smm_ctl, 8'h12, "R5");
    step(1, 0, A_CTL, 8'h00, "R6");
    step(1, 0, A_CTL, 8'h68, "R6");
    step(1, 1, A_EXT, 8'h00, "R6");
    chk(smm_ctl, 8'h12, "R6");
    chk(smm_ext, 8'hBF, "R6");
    do_reset("R7");
    step(1, 1, A_CTL, 8'h48, "R7");              // 0x4A
    chk(smm_ctl, 8'h4A, "R7");
    step(1, 0, A_EXT, 8'h07, "R7");              // 0x3F
    chk(smm_ext, 8'h3F, "R7");

    for (int i = 0; i < 600; i++) begin
      int unsigned r, sel;
      logic [7:0] a, d;
      logic we, re;
      string tag;
      r = $urandom % 100;
      if (r < 2) begin
        do_reset("R7");
        continue;
      end
      sel = $urandom % 3;
      d = 8'($urandom);
      a = (sel == 0) ? A_CTL : (sel == 1) ? A_EXT : 8'($urandom);
      if (a == A_CTL && ($urandom % 10) != 0) d[4] = 1'b0;
      we = ($urandom % 4) != 0;
      re = ($urandom % 2) != 0;
      if (m_ctl[4])                      tag = "R6";
      else if (a == A_CTL && d[4] && we) tag = "R5";
      else if (a == A_CTL)               tag = "R2";
      else if (a == A_EXT)               tag = "R3";
      else                               tag = "R4";
      step(we, re, a, d, tag);
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule